// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the load-linked reservations that several execution contexts hold on one cache line, and decides whether each store-conditional is allowed to complete. Each reservation is an inclusive byte range tagged with the context that took it. Each cycle at most one request arrives, marked as load-linked, store-conditional, plain store or line invalidate. Every request carries a context, a start address and a byte size.

A load-linked first drops every reservation whose range touches its own, whatever context owns it, and then records a new one. A store-conditional passes only when the same context holds a reservation that covers the whole store. A plain store always completes and removes only the touching reservations of other contexts, so a context's own stores leave its reservation in place. When the table is full, a new load-linked takes the slot of the reservation that was recorded earliest.

Top module: `llsc_resv_monitor`

## Requirements
- R1: While `rst_n` is low, and after reset, `live_count` is 0 and `sc_done` is 0.
- R2: A load-linked (`req_kind` = 4'b0001) removes every valid entry whose range intersects [addr, addr+size-1], whatever its context, and then inserts the entry {ctx, addr, addr+size-1}. Two ranges intersect when each one's low end is not above the other's high end.
- R3: A store-conditional (`req_kind` = 4'b0010) passes only if some valid entry has the same context and satisfies low <= addr and addr+size-1 <= high. The result appears on `sc_pass`, with `sc_done` high, in the cycle after the request, and the table update takes effect on the same edge.
- R4: A passing store-conditional removes the one entry it matched.
- R5: After any store-conditional, passing or failing, every entry of another context that intersects the store range is removed.
- R6: A plain store (`req_kind` = 4'b0100) removes only intersecting entries of other contexts. Entries of the storing context stay. With an empty table it changes nothing.
- R7: A line invalidate (`req_kind` = 4'b1000) removes all entries.
- R8: The table holds `N_ENTRIES` entries. A load-linked that finds no free entry after its own removals replaces the entry inserted earliest.
- R9: A request whose `req_kind` does not have exactly one bit set is ignored. The table is unchanged and `sc_done` stays low.
- R10: `live_count` equals the number of valid entries and never exceeds `N_ENTRIES`.
- R11: `sc_done` is high only in the cycle after an accepted store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 4 | One-hot request type: bit0 load-linked, bit1 store-conditional, bit2 plain store, bit3 invalidate |
| req_ctx | input | CTX_W | Requesting context |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Access size in bytes (at least 1) |
| sc_done | output | 1 | Store-conditional result valid |
| sc_pass | output | 1 | Store-conditional succeeded (valid with sc_done) |
| live_count | output | $clog2(N_ENTRIES+1) | Number of valid reservation entries |

## Verification
The hardest case to reach is eviction of the earliest entry on a full table after removals have punched holes into it. The slot order then no longer follows insertion order, and only a later store-conditional shows which reservation was lost. The stimulus fills the table with disjoint load-linked requests, frees one slot with a foreign store, refills the table and overflows it. It then probes each context with a store-conditional. Random traffic confined to a 64-byte window, with store-conditionals that often reuse a context's last load-linked range, repeats this under many interleavings. A bench model that orders entries by sequence number supplies the expected results.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  // bit positions of the one-hot request type
  localparam int unsigned K_LL  = 0;
  localparam int unsigned K_SC  = 1;
  localparam int unsigned K_ST  = 2;
  localparam int unsigned K_INV = 3;
  localparam int unsigned KIND_W = 4;
endpackage

// File: rtl/llsc_entry_cmp.sv
module llsc_entry_cmp #(
  parameter int unsigned CTX_W  = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              ent_valid,
  input  logic [CTX_W-1:0]  ent_ctx,
  input  logic [ADDR_W-1:0] ent_lo,
  input  logic [ADDR_W-1:0] ent_hi,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  output logic              hit_overlap,
  output logic              hit_foreign,
  output logic              hit_owned
);
  logic same_ctx;
  logic covers;

  always_comb begin
    same_ctx    = (ent_ctx == req_ctx);
    covers      = (req_lo >= ent_lo) && (req_hi <= ent_hi);
    hit_overlap = ent_valid && (req_lo <= ent_hi) && (req_hi >= ent_lo);
    hit_foreign = hit_overlap && !same_ctx;
    hit_owned   = ent_valid && same_ctx && covers;
  end
endmodule

// File: rtl/llsc_slot_pick.sv
module llsc_slot_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned AGE_W = 2
) (
  input  logic [N-1:0]            free_mask,
  input  logic [N-1:0][AGE_W-1:0] age,
  output logic [N-1:0]            grant
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(N - 1);

  logic [N-1:0] first_free;
  logic [N-1:0] oldest;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      first_free[i] = free_mask[i];
      for (int j = 0; j < i; j++) begin
        if (free_mask[j]) first_free[i] = 1'b0;
      end
      oldest[i] = (age[i] == AGE_MAX);
    end
    grant = (|free_mask) ? first_free : oldest;
  end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned CTX_W     = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SIZE_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [3:0]                     req_kind,
  input  logic [CTX_W-1:0]               req_ctx,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [SIZE_W-1:0]              req_size,
  output logic                           sc_done,
  output logic                           sc_pass,
  output logic [$clog2(N_ENTRIES+1)-1:0] live_count
);
  localparam int unsigned AGE_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int unsigned CNT_W = $clog2(N_ENTRIES + 1);

  // table state
  logic [N_ENTRIES-1:0]             valid_q, valid_n;
  logic [N_ENTRIES-1:0][CTX_W-1:0]  ctx_q, ctx_n;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] lo_q, lo_n;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] hi_q, hi_n;
  logic [N_ENTRIES-1:0][AGE_W-1:0]  age_q, age_n;
  logic                             done_q, done_n;
  logic                             pass_q, pass_n;
  logic [CNT_W-1:0]                 cnt_q, cnt_n;

  // request decode
  logic              accept, do_ll, do_sc, do_st, do_inv;
  logic [ADDR_W-1:0] req_hi;

  always_comb begin
    accept = req_valid && $onehot(req_kind);
    do_ll  = accept && req_kind[K_LL];
    do_sc  = accept && req_kind[K_SC];
    do_st  = accept && req_kind[K_ST];
    do_inv = accept && req_kind[K_INV];
    req_hi = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
  end

  // per-entry range comparison
  logic [N_ENTRIES-1:0] overlap, foreign, owned;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    llsc_entry_cmp #(.CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_cmp (
      .ent_valid  (valid_q[g]),
      .ent_ctx    (ctx_q[g]),
      .ent_lo     (lo_q[g]),
      .ent_hi     (hi_q[g]),
      .req_ctx    (req_ctx),
      .req_lo     (req_addr),
      .req_hi     (req_hi),
      .hit_overlap(overlap[g]),
      .hit_foreign(foreign[g]),
      .hit_owned  (owned[g])
    );
  end

  // first matching owned entry (search stops at the lowest index)
  logic [N_ENTRIES-1:0] first_own;
  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      first_own[i] = owned[i];
      for (int j = 0; j < i; j++) begin
        if (owned[j]) first_own[i] = 1'b0;
      end
    end
  end

  // victim choice for a load-linked, after its own removals
  logic [N_ENTRIES-1:0] kept_ll, victim;
  logic [AGE_W-1:0]     victim_age;

  assign kept_ll = valid_q & ~overlap;

  llsc_slot_pick #(.N(N_ENTRIES), .AGE_W(AGE_W)) u_pick (
    .free_mask(~kept_ll),
    .age      (age_q),
    .grant    (victim)
  );

  always_comb begin
    victim_age = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (victim[i]) victim_age = age_q[i];
    end
  end

  // next-state
  always_comb begin
    valid_n = valid_q;
    ctx_n   = ctx_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    age_n   = age_q;
    done_n  = do_sc;
    pass_n  = do_sc && (|owned);
    if (do_inv) begin
      valid_n = '0;
    end else if (do_ll) begin
      valid_n = kept_ll | victim;
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (victim[i]) begin
          ctx_n[i] = req_ctx;
          lo_n[i]  = req_addr;
          hi_n[i]  = req_hi;
          age_n[i] = '0;
        end else if (age_q[i] < victim_age) begin
          age_n[i] = age_q[i] + AGE_W'(1);
        end
      end
    end else if (do_sc) begin
      valid_n = valid_q & ~foreign & ~first_own;
    end else if (do_st) begin
      valid_n = valid_q & ~foreign;
    end
    cnt_n = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      cnt_n = cnt_n + CNT_W'(valid_n[i]);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      cnt_q   <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        age_q[i] <= AGE_W'(i);
        ctx_q[i] <= '0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end
    end else begin
      valid_q <= valid_n;
      done_q  <= done_n;
      pass_q  <= pass_n;
      cnt_q   <= cnt_n;
      if (do_ll) begin
        ctx_q <= ctx_n;
        lo_q  <= lo_n;
        hi_q  <= hi_n;
        age_q <= age_n;
      end
    end
  end

  assign sc_done    = done_q;
  assign sc_pass    = pass_q;
  assign live_count = cnt_q;

  // assertions
  p_ll_inserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 4'b0001 |=> live_count != 0);

  p_sc_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(req_valid && req_kind == 4'b0010));

  p_sc_consumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done && sc_pass |-> live_count < $past(live_count));

  p_inv_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 4'b1000 |=> live_count == 0);

  p_victim_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_ll |-> $onehot(victim));

  p_bad_kind_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !$onehot(req_kind) |=> live_count == $past(live_count) && !sc_done);

  p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live_count <= N_ENTRIES);

  p_store_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 4'b0100 |=> !sc_done);
endmodule

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb;
  localparam int N = 4;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_kind;
  logic [3:0] req_ctx;
  logic [15:0] req_addr;
  logic [3:0] req_size;
  logic       sc_done;
  logic       sc_pass;
  logic [2:0] live_count;

  int n_chk;
  int n_bad;
  bit finished;

  llsc_resv_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_size(req_size),
    .sc_done(sc_done), .sc_pass(sc_pass), .live_count(live_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model
  bit m_v[N];
  int m_ctx[N];
  int m_lo[N];
  int m_hi[N];
  int m_seq[N];
  int seq_ctr;
  int last_a[4];
  int last_s[4];

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < N; i++) if (m_v[i]) c++;
    return c;
  endfunction

  function automatic void m_drop_foreign(int c, int lo, int hi);
    for (int i = 0; i < N; i++)
      if (m_v[i] && lo <= m_hi[i] && hi >= m_lo[i] && m_ctx[i] != c) m_v[i] = 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(bit [3:0] k, int c, int a, int s, string tag);
    bit exp_done = 0;
    bit exp_pass = 0;
    int lo = a;
    int hi = a + s - 1;
    req_valid = 1'b1;
    req_kind  = k;
    req_ctx   = 4'(c);
    req_addr  = 16'(a);
    req_size  = 4'(s);
    if ($countones(k) == 1) begin
      case (k)
        4'b0001: begin
          int slot = -1;
          for (int i = 0; i < N; i++)
            if (m_v[i] && lo <= m_hi[i] && hi >= m_lo[i]) m_v[i] = 0;
          for (int i = 0; i < N; i++) if (!m_v[i] && slot < 0) slot = i;
          if (slot < 0) begin
            slot = 0;
            for (int i = 1; i < N; i++) if (m_seq[i] < m_seq[slot]) slot = i;
          end
          m_v[slot] = 1; m_ctx[slot] = c; m_lo[slot] = lo; m_hi[slot] = hi;
          m_seq[slot] = seq_ctr++;
          last_a[c % 4] = a; last_s[c % 4] = s;
        end
        4'b0010: begin
          exp_done = 1;
          for (int i = 0; i < N; i++)
            if (!exp_pass && m_v[i] && m_ctx[i] == c && lo >= m_lo[i] && hi <= m_hi[i]) begin
              exp_pass = 1; m_v[i] = 0;
            end
          m_drop_foreign(c, lo, hi);
        end
        4'b0100: m_drop_foreign(c, lo, hi);
        default: for (int i = 0; i < N; i++) m_v[i] = 0;
      endcase
    end
    @(negedge clk);
    if (exp_done) begin
      check(sc_done === 1'b1, {tag, " R3 sc_done"}, int'(sc_done), 1);
      check(sc_pass === exp_pass, {tag, " R3 sc_pass"}, int'(sc_pass), int'(exp_pass));
    end else begin
      check(sc_done === 1'b0, {tag, " R11 sc_done"}, int'(sc_done), 0);
    end
    check(live_count == m_count(), {tag, " R10 live_count"}, int'(live_count), m_count());
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    n_chk = 0; n_bad = 0; seq_ctr = 0; finished = 0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_seq[i] = 0; end
    for (int i = 0; i < 4; i++) begin last_a[i] = 0; last_s[i] = 1; end
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_ctx = '0; req_addr = '0; req_size = 4'd1;
    repeat (3) @(negedge clk);
    check(live_count == 0 && sc_done == 1'b0, "R1 reset", int'(live_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(live_count == 0 && sc_done == 1'b0, "R1 after reset", int'(live_count), 0);

    // R6: plain store with empty table
    issue(4'b0100, 1, 8, 4, "R6 empty");
    // R3/R4: LL then matching SC passes and consumes
    issue(4'b0001, 0, 16, 8, "R2 ll");
    issue(4'b0010, 0, 18, 4, "R4 pass");
    issue(4'b0010, 0, 18, 4, "R4 consumed");
    // R6: own store keeps, foreign store kills
    issue(4'b0001, 0, 16, 8, "R2 ll");
    issue(4'b0100, 0, 16, 2, "R6 own store");
    issue(4'b0010, 0, 16, 8, "R6 own survives");
    issue(4'b0001, 0, 16, 8, "R2 ll");
    issue(4'b0100, 1, 23, 2, "R6 foreign store");
    issue(4'b0010, 0, 16, 4, "R6 foreign killed");
    // R2: LL of another context removes overlapping entry
    issue(4'b0001, 0, 32, 4, "R2 ll");
    issue(4'b0001, 1, 34, 4, "R2 steal");
    issue(4'b0010, 0, 32, 2, "R2 victim fails");
    // R3: uncovered range fails; R5: failing SC removes foreign
    issue(4'b0001, 2, 40, 4, "R2 ll");
    issue(4'b0010, 2, 42, 4, "R3 not covered");
    issue(4'b0010, 3, 40, 1, "R5 foreign sc");
    issue(4'b0010, 2, 40, 4, "R5 removed");
    // R8: overflow evicts the earliest entry
    issue(4'b1000, 0, 0, 1, "R7 inv");
    issue(4'b0001, 0, 0, 4, "R8 fill");
    issue(4'b0001, 1, 8, 4, "R8 fill");
    issue(4'b0001, 2, 16, 4, "R8 fill");
    issue(4'b0001, 3, 24, 4, "R8 fill");
    issue(4'b0100, 0, 9, 1, "R8 hole");
    issue(4'b0001, 1, 32, 4, "R8 refill");
    issue(4'b0001, 2, 40, 4, "R8 overflow");
    issue(4'b0010, 0, 0, 4, "R8 oldest gone");
    issue(4'b0010, 2, 16, 4, "R8 kept");
    issue(4'b0010, 3, 24, 4, "R8 kept");
    // R9: illegal kinds ignored
    issue(4'b0011, 1, 32, 4, "R9 two-hot");
    issue(4'b0000, 1, 32, 4, "R9 zero");
    issue(4'b1001, 1, 32, 4, "R9 inv+ll");
    issue(4'b0010, 1, 32, 4, "R9 state kept");
    // R7
    issue(4'b0001, 3, 50, 2, "R7 ll");
    issue(4'b1000, 3, 0, 1, "R7 inv");
    issue(4'b0010, 3, 50, 2, "R7 cleared");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 20);
      int c = int'($urandom % 4);
      int a = int'($urandom % 64);
      int s = 1 + int'($urandom % 8);
      bit [3:0] k;
      if (r < 7) k = 4'b0001;
      else if (r < 12) begin
        k = 4'b0010;
        if ($urandom % 2 == 0) begin
          a = last_a[c] + int'($urandom % 2);
          s = last_s[c] > 1 ? last_s[c] - 1 : 1;
        end
      end
      else if (r < 17) k = 4'b0100;
      else if (r == 17) k = 4'b1000;
      else k = (r == 18) ? 4'b0110 : 4'b0000;
      issue(k, c, a, s, "R10 random");
    end

    // reset in the middle
    issue(4'b0001, 1, 4, 4, "R2 ll");
    rst_n = 1'b0;
    @(negedge clk);
    check(live_count == 0 && sc_done == 1'b0, "R1 reset again", int'(live_count), 0);
    finish_run();
  end
endmodule